// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects a set of level-sensitive interrupt sources and tells the CPU which one to serve next. Each source has a fixed 12-bit vector code. The code of source `i` is `VEC_BASE + i*VEC_STEP`, which by default is `0x400 + 0x20*i`. A parameter table ties each source to one of a number of 4-bit priority fields. When several sources point at the same field, they form a group and all members run at that field's level.

The priority fields are held in two kinds of register. A narrow register is 16 bits wide and carries four fields. A wide register is 32 bits wide and carries eight fields. A mask register holds one bit per source. It has two write addresses: one sets mask bits and the other clears them. Both addresses read back the current mask. The arbiter looks at every source that is pending, unmasked and has a nonzero priority. It registers the winner's level and vector on the CPU-facing outputs.

Top module: `intc_grp_top`

## Requirements
- R1: After synchronous reset, `irq_req`, `irq_level` and `irq_vector` are 0, every priority field reads 0 and the mask reads 0 (all sources unmasked).
- R2: Narrow priority register `r` sits at offset `r` (defaults: offsets 0 and 1). Its field `4r+k` occupies data bits `[4k+3:4k]`. A read returns the stored 16 bits, zero-extended to 32 bits.
- R3: Wide priority register `w` sits at offset `N_NARROW+w` (default: offset 2). It holds fields `4*N_NARROW+8w+k` at bits `[4k+3:4k]` and reads back all 32 bits.
- R4: A write to the set offset (`N_NARROW+N_WIDE`, default 3) ORs the 1 bits of the data into the mask. A write to the clear offset (default 4) clears the mask bits where the data holds 1. Zero data bits leave the mask unchanged. Reads at either offset return the mask in bits `[NUM_SRC-1:0]`. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R5: A source whose field holds 0 never raises a request, even while it is pending and unmasked.
- R6: Every source mapped to the same field requests at that field's current level. With the default map, sources 3 to 6 share field 2, sources 0 and 1 share field 0, and sources 8 and 9 share field 4.
- R7: Among pending, unmasked sources with nonzero priority, the one with the highest priority wins. With no such source, `irq_req` is 0.
- R8: When two or more eligible sources have the same level, the one with the lower index wins.
- R9: While `irq_req` is 1, `irq_level` equals the winner's field value and `irq_vector` equals `VEC_BASE + index*VEC_STEP`.
- R10: The outputs are registered. A change of `src_lvl`, the mask or a field is seen on the outputs after the next rising edge. While `irq_req` is 0, both `irq_level` and `irq_vector` are 0.
- R11: A source whose mask bit is 1 is never selected, while other eligible sources are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | NUM_SRC | Level of each interrupt source, 1 = pending |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_req | output | 1 | An interrupt is requested |
| irq_level | output | 4 | Priority level of the selected source |
| irq_vector | output | 12 | Vector code of the selected source |

## Verification
The assertions assume three things about the inputs. `src_lvl` and the bus strobes are synchronous to `clk` and stable around the rising edge. `bus_wr` and `bus_rd` are never aimed at offsets outside the decoded range. The set and clear offsets are never written in the same cycle, which the single address port already rules out. The mask-tracking property compares the mask against the data bits of a set or clear write one cycle later, so the bench only changes strobes and data at the falling edge. It drives `src_lvl` only between edges, and it uses only the five decoded offsets. Upper data bits above `NUM_SRC` in mask writes are left at 0.

// File: rtl/intc_grp_pkg.sv
package intc_grp_pkg;
   localparam int PRIO_W        = 4;
   localparam int FSEL_W        = 4;
   localparam int VEC_W         = 12;
   localparam int BUS_W         = 32;
   localparam int NARROW_BITS   = 16;
   localparam int WIDE_BITS     = 32;
   localparam int NARROW_FIELDS = NARROW_BITS / PRIO_W;
   localparam int WIDE_FIELDS   = WIDE_BITS / PRIO_W;

   typedef logic [PRIO_W-1:0] prio_t;
   typedef logic [VEC_W-1:0]  vec_t;

   // vector code of one source, laid out on a fixed grid
   function automatic vec_t vec_code(input int base, input int step, input int idx);
      return vec_t'(base + idx * step);
   endfunction
endpackage

// File: rtl/intc_prio_bank.sv
module intc_prio_bank
   import intc_grp_pkg::*;
#(
   parameter int N_NARROW = 2,
   parameter int N_WIDE   = 1,
   parameter int ADDR_W   = 4,
   localparam int N_FIELDS   = N_NARROW * NARROW_FIELDS + N_WIDE * WIDE_FIELDS,
   localparam int FIELD_BITS = N_FIELDS * PRIO_W
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [BUS_W-1:0]      wdata,
   output logic [FIELD_BITS-1:0] field_prio
);
   localparam int WIDE_LSB = N_NARROW * NARROW_BITS;

   // narrow registers: four fields each, contiguous in the flat field vector
   for (genvar r = 0; r < N_NARROW; r++) begin : g_narrow
      logic [NARROW_BITS-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (wr && addr == ADDR_W'(r))
            q <= wdata[NARROW_BITS-1:0];
      end
      assign field_prio[r*NARROW_BITS +: NARROW_BITS] = q;
   end

   // wide registers: eight fields each, placed after the narrow ones
   for (genvar w = 0; w < N_WIDE; w++) begin : g_wide
      logic [WIDE_BITS-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (wr && addr == ADDR_W'(N_NARROW + w))
            q <= wdata[WIDE_BITS-1:0];
      end
      assign field_prio[WIDE_LSB + w*WIDE_BITS +: WIDE_BITS] = q;
   end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
   parameter int NUM_SRC = 16,
   parameter int ADDR_W  = 4,
   parameter int SET_OFS = 3,
   parameter int CLR_OFS = 4
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] mask
);
   logic hit_set, hit_clr;

   assign hit_set = wr && (addr == ADDR_W'(SET_OFS));
   assign hit_clr = wr && (addr == ADDR_W'(CLR_OFS));

   always_ff @(posedge clk) begin
      if (rst)
         mask <= '0;
      else if (hit_set)
         mask <= mask | wdata;
      else if (hit_clr)
         mask <= mask & ~wdata;
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_grp_pkg::*;
#(
   parameter int NUM_SRC  = 16,
   parameter int N_FIELDS = 16,
   parameter logic [NUM_SRC*FSEL_W-1:0] SRC_FIELD = '0,
   parameter int VEC_BASE = 'h400,
   parameter int VEC_STEP = 'h20,
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_SRC-1:0]         src_lvl,
   input  logic [NUM_SRC-1:0]         mask,
   input  logic [N_FIELDS*PRIO_W-1:0] field_prio,
   output logic                       irq_req,
   output prio_t                      irq_level,
   output vec_t                       irq_vector
);
   prio_t              src_prio [NUM_SRC];
   vec_t               src_vec  [NUM_SRC];
   logic [NUM_SRC-1:0] elig;

   // per-source view: the field it listens to, its eligibility, its code
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int FIDX = int'(SRC_FIELD[i*FSEL_W +: FSEL_W]);
      if (FIDX >= N_FIELDS) begin : g_bad_map
         $error("source mapped to a field that does not exist");
      end
      assign src_prio[i] = field_prio[FIDX*PRIO_W +: PRIO_W];
      assign src_vec[i]  = vec_code(VEC_BASE, VEC_STEP, i);
      assign elig[i]     = src_lvl[i] && !mask[i] && (src_prio[i] != '0);
   end

   prio_t            best_lvl;
   logic [IDX_W-1:0] best_idx;
   logic             found;

   // ascending scan; strict compare keeps the lowest index on a tie
   always_comb begin
      best_lvl = '0;
      best_idx = '0;
      found    = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (src_prio[i] > best_lvl)) begin
            best_lvl = src_prio[i];
            best_idx = IDX_W'(i);
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_req    <= 1'b0;
         irq_level  <= '0;
         irq_vector <= '0;
      end else if (found) begin
         irq_req    <= 1'b1;
         irq_level  <= best_lvl;
         irq_vector <= src_vec[best_idx];
      end else begin
         irq_req    <= 1'b0;
         irq_level  <= '0;
         irq_vector <= '0;
      end
   end
endmodule

// File: rtl/intc_grp_top.sv
module intc_grp_top
   import intc_grp_pkg::*;
#(
   parameter int NUM_SRC  = 16,
   parameter int N_NARROW = 2,
   parameter int N_WIDE   = 1,
   parameter int ADDR_W   = 4,
   parameter int VEC_BASE = 'h400,
   parameter int VEC_STEP = 'h20,
   parameter logic [NUM_SRC*FSEL_W-1:0] SRC_FIELD = 64'hFC98_6544_3222_2100
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_req,
   output logic [3:0]         irq_level,
   output logic [11:0]        irq_vector
);
   localparam int N_FIELDS = N_NARROW * NARROW_FIELDS + N_WIDE * WIDE_FIELDS;
   localparam int SET_OFS  = N_NARROW + N_WIDE;
   localparam int CLR_OFS  = SET_OFS + 1;
   localparam int WIDE_LSB = N_NARROW * NARROW_BITS;

   // elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > BUS_W) begin : g_chk_src
      $error("NUM_SRC must lie in 2..32");
   end
   if (N_FIELDS > (1 << FSEL_W)) begin : g_chk_fields
      $error("more priority fields than the source map can address");
   end
   if (CLR_OFS >= (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too small for the register set");
   end
   if (VEC_BASE + (NUM_SRC - 1) * VEC_STEP >= (1 << VEC_W)) begin : g_chk_vec
      $error("vector codes overflow 12 bits");
   end

   logic [N_FIELDS*PRIO_W-1:0] field_prio;
   logic [NUM_SRC-1:0]         mask_bits;
   logic [31:0]                rd_mux;

   intc_prio_bank #(
      .N_NARROW (N_NARROW),
      .N_WIDE   (N_WIDE),
      .ADDR_W   (ADDR_W)
   ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .wr         (bus_wr),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .field_prio (field_prio)
   );

   intc_mask_reg #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W),
      .SET_OFS (SET_OFS),
      .CLR_OFS (CLR_OFS)
   ) u_mask (
      .clk   (clk),
      .rst   (rst),
      .wr    (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata[NUM_SRC-1:0]),
      .mask  (mask_bits)
   );

   intc_arbiter #(
      .NUM_SRC   (NUM_SRC),
      .N_FIELDS  (N_FIELDS),
      .SRC_FIELD (SRC_FIELD),
      .VEC_BASE  (VEC_BASE),
      .VEC_STEP  (VEC_STEP)
   ) u_arb (
      .clk        (clk),
      .rst        (rst),
      .src_lvl    (src_lvl),
      .mask       (mask_bits),
      .field_prio (field_prio),
      .irq_req    (irq_req),
      .irq_level  (irq_level),
      .irq_vector (irq_vector)
   );

   // read-back multiplexer
   always_comb begin
      rd_mux = '0;
      for (int r = 0; r < N_NARROW; r++) begin
         if (bus_addr == ADDR_W'(r))
            rd_mux = 32'(field_prio[r*NARROW_BITS +: NARROW_BITS]);
      end
      for (int w = 0; w < N_WIDE; w++) begin
         if (bus_addr == ADDR_W'(N_NARROW + w))
            rd_mux = field_prio[WIDE_LSB + w*WIDE_BITS +: WIDE_BITS];
      end
      if (bus_addr == ADDR_W'(SET_OFS) || bus_addr == ADDR_W'(CLR_OFS))
         rd_mux = 32'(mask_bits);
   end

   always_ff @(posedge clk) begin
      if (rst)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/intc_grp_chk.sv
module intc_grp_chk #(
   parameter int NUM_SRC  = 16,
   parameter int ADDR_W   = 4,
   parameter int SET_OFS  = 3,
   parameter int CLR_OFS  = 4,
   parameter int VEC_BASE = 'h400,
   parameter int VEC_STEP = 'h20
)(
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] src_lvl,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [NUM_SRC-1:0] wdata_lo,
   input logic               irq_req,
   input logic [3:0]         irq_level,
   input logic [11:0]        irq_vector,
   input logic [NUM_SRC-1:0] mask_bits
);
   logic [NUM_SRC-1:0] mask_d;
   logic [11:0]        rel;
   int                 win_idx;
   logic               on_grid;
   logic               win_masked;

   always_ff @(posedge clk) begin
      if (rst) mask_d <= '0;
      else     mask_d <= mask_bits;
   end

   always_comb begin
      rel        = irq_vector - 12'(VEC_BASE);
      on_grid    = (irq_vector >= 12'(VEC_BASE)) && ((int'(rel) % VEC_STEP) == 0);
      win_idx    = int'(rel) / VEC_STEP;
      win_masked = |(mask_d & (NUM_SRC'(1) << win_idx));
   end

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
      !irq_req |-> (irq_level == 4'd0 && irq_vector == 12'd0));

   assert_level_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> irq_level != 4'd0);

   assert_vector_grid_R9: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> on_grid && (win_idx < NUM_SRC));

   assert_quiet_without_sources_R7: assert property (@(posedge clk) disable iff (rst)
      (src_lvl == '0) |=> !irq_req);

   assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(SET_OFS)) |=>
         ((mask_bits & $past(wdata_lo)) == $past(wdata_lo)));

   assert_mask_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(CLR_OFS)) |=>
         ((mask_bits & $past(wdata_lo)) == '0));

   assert_winner_unmasked_R11: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> !win_masked);
endmodule

bind intc_grp_top intc_grp_chk #(
   .NUM_SRC  (NUM_SRC),
   .ADDR_W   (ADDR_W),
   .SET_OFS  (SET_OFS),
   .CLR_OFS  (CLR_OFS),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .src_lvl    (src_lvl),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .wdata_lo   (bus_wdata[NUM_SRC-1:0]),
   .irq_req    (irq_req),
   .irq_level  (irq_level),
   .irq_vector (irq_vector),
   .mask_bits  (mask_bits)
);

// File: tb/tb_intc_grp_top.sv
module tb_intc_grp_top;
   localparam int NSRC = 16;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NSRC-1:0] src_lvl = '0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [3:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            irq_req;
   logic [3:0]      irq_level;
   logic [11:0]     irq_vector;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   // 8 time units per period: 125 MHz at 1 ns
   always #4 clk = ~clk;

   intc_grp_top dut (
      .clk(clk), .rst(rst), .src_lvl(src_lvl),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
   );

   // offsets: 0,1 narrow, 2 wide, 3 mask set, 4 mask clear
   // field map: src0,1->f0  src2->f1  src3..6->f2  src7->f3  src8,9->f4
   //            src10->f5 src11->f6 src12->f8 src13->f9 src14->f12 src15->f15
   // entry = {src[15:0], req, level[3:0], vector[11:0]}
   localparam logic [32:0] TBL [15] = '{
      {16'h0000, 1'b0, 4'd0,  12'h000},   // R7 nothing pending
      {16'h0001, 1'b1, 4'd3,  12'h400},   // R9
      {16'h0003, 1'b1, 4'd3,  12'h400},   // R8 group tie
      {16'h0002, 1'b1, 4'd3,  12'h420},   // R6 shared field
      {16'h0006, 1'b1, 4'd5,  12'h440},   // R7
      {16'h0040, 1'b1, 4'd7,  12'h4C0},   // R6
      {16'h0030, 1'b1, 4'd7,  12'h480},   // R8
      {16'h0080, 1'b0, 4'd0,  12'h000},   // R5 field 3 is zero
      {16'h0300, 1'b1, 4'd7,  12'h500},   // R8
      {16'h0140, 1'b1, 4'd7,  12'h4C0},   // R8 across fields
      {16'h1800, 1'b1, 4'd9,  12'h560},   // R8 wide vs narrow
      {16'h4000, 1'b1, 4'd15, 12'h5C0},   // R3
      {16'hFFFF, 1'b1, 4'd15, 12'h5C0},   // R7
      {16'hA400, 1'b1, 4'd4,  12'h5E0},   // R7
      {16'h2000, 1'b1, 4'd1,  12'h5A0}    // R3
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      step();
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic chk_out(input string req, input logic r, input logic [3:0] l,
                          input logic [11:0] v);
      chk(req, "irq_req",    32'(irq_req),    32'(r));
      chk(req, "irq_level",  32'(irq_level),  32'(l));
      chk(req, "irq_vector", 32'(irq_vector), 32'(v));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk_out("R1", 1'b0, 4'd0, 12'h000);
      bus_read(4'd0, rd); chk("R1", "narrow reg 0", rd, 32'h0);
      bus_read(4'd2, rd); chk("R1", "wide reg", rd, 32'h0);
      bus_read(4'd3, rd); chk("R1", "mask", rd, 32'h0);

      // R2, R3 program the fields and read them back
      bus_write(4'd0, 32'hFFFF_0753);
      bus_write(4'd1, 32'h0000_0927);
      bus_write(4'd2, 32'h400F_0019);
      bus_read(4'd0, rd); chk("R2", "narrow reg 0 readback", rd, 32'h0000_0753);
      bus_read(4'd1, rd); chk("R2", "narrow reg 1 readback", rd, 32'h0000_0927);
      bus_read(4'd2, rd); chk("R3", "wide reg readback", rd, 32'h400F_0019);

      // table walk
      for (int k = 0; k < 15; k++) begin
         src_lvl = TBL[k][32:17];
         step();
         chk_out($sformatf("R7 table %0d", k), TBL[k][16], TBL[k][15:12], TBL[k][11:0]);
      end

      // R10 outputs lag the input by one edge
      src_lvl = '0;
      step();
      src_lvl = 16'h0001;
      #1;
      chk("R10", "irq_req before edge", 32'(irq_req), 32'h0);
      @(negedge clk);
      chk_out("R10", 1'b1, 4'd3, 12'h400);

      // R5 a field cleared to zero silences its sources
      bus_write(4'd0, 32'h0000_0750);
      step();
      chk_out("R5", 1'b0, 4'd0, 12'h000);
      bus_write(4'd0, 32'h0000_0753);

      // R6 a group follows its field's new level
      bus_write(4'd0, 32'h0000_0B53);
      src_lvl = 16'h0020;
      step();
      chk_out("R6", 1'b1, 4'd11, 12'h4A0);
      src_lvl = 16'h0048;
      step();
      chk_out("R6", 1'b1, 4'd11, 12'h460);
      bus_write(4'd0, 32'h0000_0753);

      // R4, R11 mask set and clear
      src_lvl = 16'hFFFF;
      bus_write(4'd3, 32'h0000_4000);
      step();
      chk_out("R11", 1'b1, 4'd9, 12'h560);
      bus_write(4'd3, 32'h0000_0800);
      step();
      chk_out("R11", 1'b1, 4'd9, 12'h580);
      bus_read(4'd3, rd); chk("R4", "mask after two sets", rd, 32'h0000_4800);
      bus_write(4'd4, 32'h0000_4000);
      bus_read(4'd4, rd); chk("R4", "mask after clear", rd, 32'h0000_0800);
      step();
      chk_out("R4", 1'b1, 4'd15, 12'h5C0);
      bus_write(4'd4, 32'h0000_0800);
      bus_read(4'd3, rd); chk("R4", "mask cleared", rd, 32'h0);

      // R11 all sources masked: no request
      bus_write(4'd3, 32'h0000_FFFF);
      step();
      chk_out("R11", 1'b0, 4'd0, 12'h000);
      bus_write(4'd4, 32'h0000_FFFF);
      src_lvl = '0;
      step();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule